// File: doc/BRIEF.md
# Compare-Match PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter, a stored duty value and a registered set/clear output stage. The counter runs through all 2^W codes and wraps. The count of zero starts a pulse. A match between the count and the stored duty value ends it. The high time per period therefore equals the stored value in clock cycles.

The duty value arrives on a W-bit input. It is captured on the rising edge of a load strobe into a holding register. It becomes the active value only when the counter wraps, so a load in the middle of a period never cuts a pulse short or drops one. The count and both decode flags are brought out for observation.

Top module: `pwm_cmp_top`

## Requirements
- R1: The counter starts at 0 after reset and advances by one on every clock edge. It wraps from 2^W-1 to 0, giving a period of 2^W clocks (256 at the default W=8).
- R2: The holding register takes `duty_in` at a clock edge where `duty_ld` is 1 and was 0 at the previous edge. Holding `duty_ld` at 1, or changing `duty_in` at any other time, has no effect.
- R3: The active duty value is copied from the holding register only at the edge where the counter goes from 2^W-1 to 0. A load during a period leaves the remainder of that period unchanged.
- R4: `zero_o` is 1 exactly when the count is 0. `eq_o` is 1 exactly when the count equals the active duty value, bit for bit.
- R5: At each edge, `pwm_o` becomes 0 if `eq_o` is 1, otherwise 1 if `zero_o` is 1, otherwise it keeps its value. The clear condition wins over the set condition.
- R6: With an active duty value D, `pwm_o` is high for exactly D cycles of every period (at the counts 1 to D), for D = 1, 26, 64, 128, 192 and 2^W-1.
- R7: With D = 0, `pwm_o` stays 0 for the whole period, because the match and zero conditions coincide and the clear wins.
- R8: While `rst_n` is 0, the counter, holding register, active duty, load history and output are 0. The release is synchronised over two clock edges, so the counter first changes at the third rising edge after `rst_n` rises.
- R9: The width W is a parameter that sets the counter, registers and both comparators, giving 2^W levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| duty_in | input | W | Requested duty value |
| duty_ld | input | 1 | Load strobe, acts on its rising edge |
| pwm_o | output | 1 | PWM output |
| cnt_o | output | W | Current counter value |
| zero_o | output | 1 | Count-is-zero flag |
| eq_o | output | 1 | Count-equals-duty flag |

## Verification
The count, the output and the loaded value change one edge after their cause. Both flags are combinational on registered state, so they are valid in the same cycle as the count. A new duty value reaches the flags at the first wrap after the load edge, which can be up to one full period later. The bench advances a behavioural model at every rising edge and compares all outputs at the following falling edge. Its high-time counts use windows that open at a count of zero, and only after two wraps have passed since the load.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  // Decoded compare results handed from the comparator to the output stage.
  typedef struct packed {
    logic at_zero;
    logic at_duty;
  } pwm_flags_t;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/pwm_free_cnt.sv
module pwm_free_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  localparam logic [W-1:0] LAST = {W{1'b1}};
  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = (cnt_q == LAST);

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) + STEP));

  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_duty_store.sv
module pwm_duty_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] duty_in,
  input  logic         duty_ld,
  input  logic         wrap,
  output logic [W-1:0] duty_act
);

  logic         ld_prev_q;
  logic         ld_rise;
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;
  logic [W-1:0] act_q;
  logic [W-1:0] act_d;

  // Next-state logic: edge detect, capture, apply on wrap.
  always_comb begin
    ld_rise = duty_ld & ~ld_prev_q;
    hold_d  = ld_rise ? duty_in : hold_q;
    act_d   = wrap ? hold_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_prev_q <= 1'b0;
      hold_q    <= '0;
      act_q     <= '0;
    end else begin
      ld_prev_q <= duty_ld;
      hold_q    <= hold_d;
      act_q     <= act_d;
    end
  end

  assign duty_act = act_q;

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(duty_ld && !ld_prev_q) |=> $stable(hold_q));

  assert_act_only_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q));

endmodule

// File: rtl/pwm_match.sv
module pwm_match
  import pwm_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty_act,
  output pwm_flags_t   flags
);

  logic [W-1:0] diff;

  // One XOR per bit, then a NOR reduction for each flag.
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign diff[b] = cnt[b] ^ duty_act[b];
  end

  assign flags.at_zero = ~|cnt;
  assign flags.at_duty = ~|diff;

endmodule

// File: rtl/pwm_sr_out.sv
module pwm_sr_out
  import pwm_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwm_flags_t flags,
  output logic       pwm
);

  logic out_q;
  logic out_d;

  // Clear has priority over set.
  always_comb begin
    if (flags.at_duty)      out_d = 1'b0;
    else if (flags.at_zero) out_d = 1'b1;
    else                    out_d = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pwm = out_q;

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flags.at_duty |=> !out_q);

  assert_set_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.at_zero && !flags.at_duty) |=> out_q);

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.at_zero && !flags.at_duty) |=> $stable(out_q));

endmodule

// File: rtl/pwm_cmp_top.sv
module pwm_cmp_top
  import pwm_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] duty_in,
  input  logic         duty_ld,
  output logic         pwm_o,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         eq_o
);

  logic         rst_int_n;
  logic [W-1:0] cnt;
  logic         wrap;
  logic [W-1:0] duty_act;
  pwm_flags_t   flags;

  pwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pwm_free_cnt #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  pwm_duty_store #(.W(W)) u_duty (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .duty_in  (duty_in),
    .duty_ld  (duty_ld),
    .wrap     (wrap),
    .duty_act (duty_act)
  );

  pwm_match #(.W(W)) u_match (
    .cnt      (cnt),
    .duty_act (duty_act),
    .flags    (flags)
  );

  pwm_sr_out u_out (
    .clk   (clk),
    .rst_n (rst_int_n),
    .flags (flags),
    .pwm   (pwm_o)
  );

  assign cnt_o  = cnt;
  assign zero_o = flags.at_zero;
  assign eq_o   = flags.at_duty;

  assert_idle_in_reset_R8: assert property (@(posedge clk)
    !rst_int_n |-> (!pwm_o && cnt == '0));

endmodule

// File: tb/sim_pwm_cmp_top.sv
`timescale 1ns/1ps
module sim_pwm_cmp_top;

  localparam int W   = 8;
  localparam int PER = 1 << W;
  localparam int MAXV = PER - 1;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] duty_in;
  logic         duty_ld;
  logic         pwm_o;
  logic [W-1:0] cnt_o;
  logic         zero_o;
  logic         eq_o;

  int total;
  int bad;
  bit done;

  pwm_cmp_top #(.W(W)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .duty_in (duty_in),
    .duty_ld (duty_ld),
    .pwm_o   (pwm_o),
    .cnt_o   (cnt_o),
    .zero_o  (zero_o),
    .eq_o    (eq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference, advanced on each rising edge.
  int m_s1, m_s2, m_cnt, m_hold, m_act, m_out, m_ldq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cnt = 0; m_hold = 0; m_act = 0; m_out = 0; m_ldq = 0;
    end else begin
      if (m_s2 != 0) begin
        int n_out, n_act, n_hold;
        if (m_cnt == m_act)  n_out = 0;
        else if (m_cnt == 0) n_out = 1;
        else                 n_out = m_out;
        n_act  = (m_cnt == MAXV) ? m_hold : m_act;
        n_hold = (duty_ld && m_ldq == 0) ? int'(duty_in) : m_hold;
        m_ldq  = duty_ld ? 1 : 0;
        m_cnt  = (m_cnt + 1) % PER;
        m_out  = n_out;
        m_act  = n_act;
        m_hold = n_hold;
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison at the falling edge.
  always @(negedge clk) begin
    if (!done) begin
      check("R1 count", int'(cnt_o), m_cnt);
      check("R4 zero flag", int'(zero_o), (m_cnt == 0) ? 1 : 0);
      check("R4 match flag", int'(eq_o), (m_cnt == m_act) ? 1 : 0);
      check("R5 output", int'(pwm_o), m_out);
    end
  end

  task automatic load(input int v);
    @(negedge clk);
    duty_in = W'(v);
    duty_ld = 1'b1;
    @(negedge clk);
    duty_ld = 1'b0;
  endtask

  task automatic to_zero();
    do @(negedge clk); while (cnt_o != '0);
  endtask

  // Count high cycles over n whole periods starting at a count of zero.
  task automatic high_count(input int n, output int hi);
    hi = 0;
    to_zero();
    for (int i = 0; i < n * PER; i++) begin
      if (i > 0) @(negedge clk);
      if (pwm_o) hi++;
    end
  endtask

  task automatic measure(input string req, input int d);
    int hi;
    load(d);
    to_zero();
    @(negedge clk);
    high_count(2, hi);
    check(req, hi, 2 * d);
  endtask

  initial begin
    int hi;
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; duty_in = '0; duty_ld = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset output", int'(pwm_o), 0);
    check("R8 reset count", int'(cnt_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 release edge 1", int'(cnt_o), 0);
    @(negedge clk);
    check("R8 release edge 2", int'(cnt_o), 0);
    @(negedge clk);
    check("R8 release edge 3", int'(cnt_o), 1);

    high_count(1, hi);
    check("R7 zero duty after reset", hi, 0);

    measure("R6 duty 1", 1);
    measure("R6 duty 26", 26);
    measure("R6 duty 64", 64);
    measure("R6 duty 128", 128);
    measure("R6 duty 192", 192);
    measure("R6 R9 duty max", MAXV);
    measure("R7 duty 0", 0);

    // R3: load during a period, current period keeps the old value.
    load(200);
    to_zero();
    @(negedge clk);
    to_zero();
    repeat (50) @(negedge clk);
    duty_in = W'(20); duty_ld = 1'b1;
    @(negedge clk);
    duty_ld = 1'b0;
    hi = 0;
    for (int i = 0; i < PER - 51; i++) begin
      if (pwm_o) hi++;
      @(negedge clk);
    end
    check("R3 period after early load", hi, 200 - 50);
    high_count(1, hi);
    check("R3 next period uses new value", hi, 20);

    // R2: strobe held high, data changes afterwards are ignored.
    @(negedge clk);
    duty_in = W'(40); duty_ld = 1'b1;
    @(negedge clk);
    duty_in = W'(90);
    to_zero();
    @(negedge clk);
    high_count(1, hi);
    check("R2 held strobe keeps first value", hi, 40);
    duty_ld = 1'b0;
    duty_in = W'(150);
    high_count(1, hi);
    check("R2 data without strobe ignored", hi, 40);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule